// File: doc/BRIEF.md
# VGA Raster Timing Generator with Video Output Stage

This block produces the raster timing for a 640x480 display from a single pixel clock. A horizontal counter counts pixels along a line, and a vertical counter counts lines in a frame. Both counters start at zero on the first visible pixel and the first visible line. The visible area therefore comes first in each direction. The front porch, the sync pulse and the back porch follow it. Both counters are brought out so that downstream logic can choose colours by screen position. A video-on flag marks the visible area.

A small video stage is built in. It makes one bit each of red, green and blue. A mode input chooses between two patterns: a plain white field, or eight vertical colour bars picked from the horizontal count. The colour bits are ANDed with video-on and then registered. Both sync signals also pass through one register, so that they stay aligned with the colour pins. The pixel stream flows out on every clock and has no back-pressure. A display cannot stall, so there is no valid/ready pair. The outputs are plain pins that are valid on every cycle after reset.

Top module: `raster_video_top`

## Requirements
- R1: While `rst_n` is low at a rising edge, both counters go to 0, the colour pins go to 0 and both sync pins go to 1. The reset is synchronous and active low.
- R2: `h_count` goes up by one on each clock, and wraps from 799 to 0. That gives 800 clocks per line: 640 visible, then 16 front porch, 96 sync and 48 back porch.
- R3: `v_count` goes up by one only in the cycle where `h_count` wraps, and it wraps from 524 to 0. That gives 525 lines: 480 visible, then 10 front porch, 2 sync and 33 back porch.
- R4: `video_on` is 1 exactly when `h_count` < 640 and `v_count` < 480. It is a combinational decode of the current counters.
- R5: `hsync_n` is active low. It is 0 in the cycle after `h_count` was in 656..751, and 1 otherwise. This is one register of delay.
- R6: `vsync_n` is active low. It is 0 in the cycle after `v_count` was in 490..491, and 1 otherwise. This is one register of delay.
- R7: If `video_on` was 0 in the previous cycle, then `red`, `green` and `blue` are all 0.
- R8: With `bar_mode` = 0, the colour pins are all 1 in the cycle after a cycle where `video_on` was 1.
- R9: With `bar_mode` = 1, the bar number is `h_count`/80 (0..7). The colour {red,green,blue} is 7 minus the bar number: bar 0 is white, bar 1 is {1,1,0}, and so on to bar 7, which is black. The colour pins show this value one cycle after a visible pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bar_mode | input | 1 | 0 selects the white field, 1 selects the colour bars |
| hsync_n | output | 1 | Registered horizontal sync, active low |
| vsync_n | output | 1 | Registered vertical sync, active low |
| video_on | output | 1 | High inside the visible area (current counters) |
| h_count | output | 10 | Pixel position within the line |
| v_count | output | 10 | Line position within the frame |
| red | output | 1 | Registered, gated red bit |
| green | output | 1 | Registered, gated green bit |
| blue | output | 1 | Registered, gated blue bit |

## Verification
The hardest events to reach from the ports are the vertical sync window and the wrap of the vertical counter. At the default timing, the first vertical sync comes almost 400,000 clocks after reset. The bench reaches both events by overriding the vertical timing parameters to a frame of eight lines while it keeps the full horizontal timing. Several complete frames then fit into a short run, and every line still shows all eight colour bars. The bench also changes the mode between frames and pulses reset in the middle of a line, so that the counters are seen restarting from an arbitrary position.

// File: rtl/raster_pkg.sv
package raster_pkg;

  // Number of colour bars across the visible width; the colour code is 3 bits.
  localparam int unsigned BAR_COUNT = 8;
  localparam int unsigned BAR_IDX_W = 3;

  typedef struct packed {
    logic r;
    logic g;
    logic b;
  } rgb_t;

  localparam rgb_t RGB_BLACK = '{r: 1'b0, g: 1'b0, b: 1'b0};
  localparam rgb_t RGB_WHITE = '{r: 1'b1, g: 1'b1, b: 1'b1};

  // Bar 0 is white, the last bar is black: the colour code counts down.
  function automatic rgb_t bar_to_rgb(input logic [BAR_IDX_W-1:0] idx);
    logic [BAR_IDX_W-1:0] code;
    code = ~idx;
    return '{r: code[2], g: code[1], b: code[0]};
  endfunction

endpackage

// File: rtl/raster_axis_ctr.sv
// One axis of the raster: a wrapping counter with its visible decode
// and its raw (unregistered) active-low sync window.
module raster_axis_ctr #(
  parameter int unsigned CNT_W = 10,
  parameter int unsigned VIS   = 640,
  parameter int unsigned FP    = 16,
  parameter int unsigned SYNC  = 96,
  parameter int unsigned BP    = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [CNT_W-1:0] cnt,
  output logic             at_last,
  output logic             in_vis,
  output logic             sync_raw_n
);

  localparam int unsigned TOTAL    = VIS + FP + SYNC + BP;
  localparam int unsigned SYNC_BEG = VIS + FP;
  localparam int unsigned SYNC_END = SYNC_BEG + SYNC;

  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(TOTAL - 1);
  localparam logic [CNT_W-1:0] VIS_C  = CNT_W'(VIS);
  localparam logic [CNT_W-1:0] SBEG_C = CNT_W'(SYNC_BEG);
  localparam logic [CNT_W-1:0] SEND_C = CNT_W'(SYNC_END);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (step) begin
      if (cnt == LAST_C) cnt <= '0;
      else               cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    at_last    = (cnt == LAST_C);
    in_vis     = (cnt < VIS_C);
    sync_raw_n = !((cnt >= SBEG_C) && (cnt < SEND_C));
  end

endmodule

// File: rtl/raster_color_sel.sv
// Picks the ungated colour for the current pixel: white field or bars.
module raster_color_sel
  import raster_pkg::*;
#(
  parameter int unsigned CNT_W = 10,
  parameter int unsigned H_VIS = 640
) (
  input  logic [CNT_W-1:0] h_count,
  input  logic             bar_mode,
  output rgb_t             pix
);

  localparam int unsigned BAR_W = H_VIS / BAR_COUNT;

  logic [BAR_COUNT-2:0]  past_edge;
  logic [BAR_IDX_W-1:0]  bar_idx;

  // One comparator per interior bar edge.
  for (genvar k = 1; k < BAR_COUNT; k++) begin : g_edge
    assign past_edge[k-1] = (h_count >= CNT_W'(k * BAR_W));
  end

  always_comb begin
    bar_idx = '0;
    for (int k = 0; k < BAR_COUNT - 1; k++) begin
      if (past_edge[k]) bar_idx = bar_idx + 1'b1;
    end
  end

  always_comb begin
    if (bar_mode) pix = bar_to_rgb(bar_idx);
    else          pix = RGB_WHITE;
  end

endmodule

// File: rtl/raster_out_stage.sv
// Gates colour with video-on and registers colour and sync together.
module raster_out_stage
  import raster_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic video_on,
  input  rgb_t pix,
  input  logic hs_raw_n,
  input  logic vs_raw_n,
  output logic red,
  output logic green,
  output logic blue,
  output logic hsync_n,
  output logic vsync_n
);

  rgb_t gated;

  always_comb begin
    gated.r = pix.r & video_on;
    gated.g = pix.g & video_on;
    gated.b = pix.b & video_on;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      red     <= 1'b0;
      green   <= 1'b0;
      blue    <= 1'b0;
      hsync_n <= 1'b1;
      vsync_n <= 1'b1;
    end else begin
      red     <= gated.r;
      green   <= gated.g;
      blue    <= gated.b;
      hsync_n <= hs_raw_n;
      vsync_n <= vs_raw_n;
    end
  end

endmodule

// File: rtl/raster_video_top.sv
module raster_video_top
  import raster_pkg::*;
#(
  parameter int unsigned CNT_W  = 10,
  parameter int unsigned H_VIS  = 640,
  parameter int unsigned H_FP   = 16,
  parameter int unsigned H_SYNC = 96,
  parameter int unsigned H_BP   = 48,
  parameter int unsigned V_VIS  = 480,
  parameter int unsigned V_FP   = 10,
  parameter int unsigned V_SYNC = 2,
  parameter int unsigned V_BP   = 33
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bar_mode,
  output logic             hsync_n,
  output logic             vsync_n,
  output logic             video_on,
  output logic [CNT_W-1:0] h_count,
  output logic [CNT_W-1:0] v_count,
  output logic             red,
  output logic             green,
  output logic             blue
);

  logic h_last, h_vis, h_sync_raw_n;
  logic v_last, v_vis, v_sync_raw_n;
  rgb_t pix;

  raster_axis_ctr #(
    .CNT_W(CNT_W), .VIS(H_VIS), .FP(H_FP), .SYNC(H_SYNC), .BP(H_BP)
  ) u_hctr (
    .clk(clk), .rst_n(rst_n), .step(1'b1),
    .cnt(h_count), .at_last(h_last), .in_vis(h_vis), .sync_raw_n(h_sync_raw_n)
  );

  raster_axis_ctr #(
    .CNT_W(CNT_W), .VIS(V_VIS), .FP(V_FP), .SYNC(V_SYNC), .BP(V_BP)
  ) u_vctr (
    .clk(clk), .rst_n(rst_n), .step(h_last),
    .cnt(v_count), .at_last(v_last), .in_vis(v_vis), .sync_raw_n(v_sync_raw_n)
  );

  assign video_on = h_vis & v_vis;

  raster_color_sel #(.CNT_W(CNT_W), .H_VIS(H_VIS)) u_color (
    .h_count(h_count), .bar_mode(bar_mode), .pix(pix)
  );

  raster_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .video_on(video_on), .pix(pix),
    .hs_raw_n(h_sync_raw_n), .vs_raw_n(v_sync_raw_n),
    .red(red), .green(green), .blue(blue),
    .hsync_n(hsync_n), .vsync_n(vsync_n)
  );

endmodule

// File: rtl/raster_video_chk.sv
module raster_video_chk #(
  parameter int unsigned CNT_W  = 10,
  parameter int unsigned H_VIS  = 640,
  parameter int unsigned H_FP   = 16,
  parameter int unsigned H_SYNC = 96,
  parameter int unsigned H_BP   = 48,
  parameter int unsigned V_VIS  = 480,
  parameter int unsigned V_FP   = 10,
  parameter int unsigned V_SYNC = 2,
  parameter int unsigned V_BP   = 33
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bar_mode,
  input logic             hsync_n,
  input logic             vsync_n,
  input logic             video_on,
  input logic [CNT_W-1:0] h_count,
  input logic [CNT_W-1:0] v_count,
  input logic             red,
  input logic             green,
  input logic             blue
);

  localparam logic [CNT_W-1:0] H_LAST = CNT_W'(H_VIS + H_FP + H_SYNC + H_BP - 1);
  localparam logic [CNT_W-1:0] V_LAST = CNT_W'(V_VIS + V_FP + V_SYNC + V_BP - 1);
  localparam logic [CNT_W-1:0] HS_B   = CNT_W'(H_VIS + H_FP);
  localparam logic [CNT_W-1:0] HS_E   = CNT_W'(H_VIS + H_FP + H_SYNC);
  localparam logic [CNT_W-1:0] VS_B   = CNT_W'(V_VIS + V_FP);
  localparam logic [CNT_W-1:0] VS_E   = CNT_W'(V_VIS + V_FP + V_SYNC);
  localparam logic [CNT_W-1:0] LAST_BAR = CNT_W'(H_VIS - H_VIS / 8);
  localparam logic [CNT_W-1:0] BAR_W    = CNT_W'(H_VIS / 8);

  assert_h_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (h_count == H_LAST) |=> (h_count == '0));

  assert_h_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (h_count != H_LAST) |=> (h_count == CNT_W'($past(h_count) + 1'b1)));

  assert_v_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (h_count != H_LAST) |=> $stable(v_count));

  assert_v_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (h_count == H_LAST && v_count == V_LAST) |=> (v_count == '0));

  assert_hsync_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (h_count >= HS_B && h_count < HS_E) |=> !hsync_n);

  assert_hsync_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(h_count >= HS_B && h_count < HS_E) |=> hsync_n);

  assert_vsync_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (v_count >= VS_B && v_count < VS_E) |=> !vsync_n);

  assert_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !video_on |=> !(red | green | blue));

  assert_white_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (video_on && !bar_mode) |=> (red && green && blue));

  assert_first_bar_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (video_on && bar_mode && h_count < BAR_W) |=> (red && green && blue));

  assert_last_bar_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (video_on && bar_mode && h_count >= LAST_BAR) |=> !(red | green | blue));

endmodule

bind raster_video_top raster_video_chk #(
  .CNT_W(CNT_W), .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
  .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bar_mode(bar_mode), .hsync_n(hsync_n),
  .vsync_n(vsync_n), .video_on(video_on), .h_count(h_count),
  .v_count(v_count), .red(red), .green(green), .blue(blue)
);

// File: tb/raster_video_top_tb_top.sv
module raster_video_top_tb_top;

  localparam int VV = 4, VFP = 1, VSY = 2, VBP = 1;
  localparam int VT = VV + VFP + VSY + VBP;
  localparam int HT = 800;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bar_mode = 1'b0;
  logic hsync_n, vsync_n, video_on, red, green, blue;
  logic [9:0] h_count, v_count;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    int   h, v;
    bit   von, hs, vs, in_rst;
    bit [2:0] rgb;
    string rgb_tag;
  } exp_t;

  exp_t sb[$];

  always #5 clk = ~clk;

  raster_video_top #(.V_VIS(VV), .V_FP(VFP), .V_SYNC(VSY), .V_BP(VBP)) dut_i (
    .clk(clk), .rst_n(rst_n), .bar_mode(bar_mode), .hsync_n(hsync_n),
    .vsync_n(vsync_n), .video_on(video_on), .h_count(h_count),
    .v_count(v_count), .red(red), .green(green), .blue(blue)
  );

  // Reference model state: counters after the last edge, plus registered outputs.
  int mh = 0, mv = 0;
  bit [2:0] orgb = 3'b000;
  bit ohs = 1, ovs = 1;

  // Driver side of the scoreboard: compute the expected item for each edge.
  task automatic push_expected(input bit in_rst, input bit mode);
    exp_t e;
    bit von_pre;
    string tag;
    if (in_rst) begin
      mh = 0; mv = 0; orgb = 3'b000; ohs = 1; ovs = 1; tag = "R1";
    end else begin
      von_pre = (mh < 640) && (mv < VV);
      if (!von_pre)   begin orgb = 3'b000; tag = "R7"; end
      else if (!mode) begin orgb = 3'b111; tag = "R8"; end
      else            begin orgb = 3'(7 - mh / 80); tag = "R9"; end
      ohs = !(mh >= 656 && mh <= 751);
      ovs = !(mv >= VV + VFP && mv < VV + VFP + VSY);
      if (mh == HT - 1) begin
        mh = 0;
        mv = (mv == VT - 1) ? 0 : mv + 1;
      end else begin
        mh = mh + 1;
      end
    end
    e.h = mh; e.v = mv; e.von = (mh < 640) && (mv < VV);
    e.hs = ohs; e.vs = ovs; e.rgb = orgb; e.in_rst = in_rst;
    e.rgb_tag = tag;
    sb.push_back(e);
  endtask

  always @(posedge clk) push_expected(!rst_n, bar_mode);

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at t=%0t", req, what, act, expv, $time);
    end
  endtask

  // Monitor side: pop and compare at the falling edge.
  always @(negedge clk) begin
    if (!done && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      if (e.in_rst) begin
        check(h_count == 0 && v_count == 0, "R1", "counters", h_count, 0);
        check({red, green, blue} == 3'b000, "R1", "rgb", {red, green, blue}, 0);
        check(hsync_n && vsync_n, "R1", "sync", {hsync_n, vsync_n}, 3);
      end else begin
        check(int'(h_count) == e.h, "R2", "h_count", h_count, e.h);
        check(int'(v_count) == e.v, "R3", "v_count", v_count, e.v);
        check(video_on == e.von, "R4", "video_on", video_on, e.von);
        check(hsync_n == e.hs, "R5", "hsync_n", hsync_n, e.hs);
        check(vsync_n == e.vs, "R6", "vsync_n", vsync_n, e.vs);
        check({red, green, blue} == e.rgb, e.rgb_tag, "rgb",
              {red, green, blue}, e.rgb);
      end
    end
  end

  task automatic wait_cycles(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    wait_cycles(4);
    rst_n = 1'b1;                      // R1 seen during the reset cycles
    wait_cycles(VT * HT + 50);         // white field, full frame (R8, R5, R6)
    bar_mode = 1'b1;
    wait_cycles(VT * HT + 50);         // colour bars through a vertical wrap (R9, R3)
    wait_cycles(333);
    rst_n = 1'b0;                      // mid-line reset (R1)
    wait_cycles(3);
    rst_n = 1'b1;
    bar_mode = 1'b0;
    wait_cycles(HT + 20);              // restart from zero (R2)
    @(negedge clk);
    #1;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule